// File: doc/BRIEF.md
# Authenticated Cipher Operation Sequencer

This block controls one authenticated-encryption operation of a counter-mode cipher that uses a Galois-field hash. A start pulse captures a direction bit and two byte counts: the associated-data length and the payload length. The sequencer then fetches 128-bit input words at a fixed spacing of 14 clock cycles. All associated-data words come first, then the payload words. Each payload word produces a one-cycle output-valid strobe on the following cycle.

After the last word, the sequencer asks an external hash engine to absorb a length block. This block holds the associated-data bit length in its upper 64 bits and the payload bit length in its lower 64 bits. The sequencer then waits for the engine's done pulse. That pulse ends the operation. A finish strobe marks the last busy cycle. A tag-valid strobe follows on the first idle cycle.

The cipher rounds and the multiplier sit outside this block. Only the request/done handshake for the length step is visible here. Either length may be zero. A new operation may start on the cycle right after finish.

Top module: `aead_seq`

## Requirements
- R1: A start pulse while idle captures `decrypt`, `aad_bytes` and `pay_bytes`. While busy, `op_decrypt` and `len_block` keep the captured values, even if these inputs change.
- R2: `busy` is high from the cycle after the accepted start through the finish cycle. It is low on the cycle after finish.
- R3: `finish` is high for exactly one cycle. That is the cycle in which `len_done` is high while the sequencer waits for the length step.
- R4: The first `rd_en` comes on the first busy cycle. Each later `rd_en` of the same operation comes exactly 14 cycles after the previous one.
- R5: The operation reads ceil(aad_bytes/16) words with `rd_is_aad`=1, then ceil(pay_bytes/16) words with `rd_is_aad`=0.
- R6: `dout_valid` is high for one cycle on the cycle after each payload read. It never rises for associated-data reads, nor at all when `pay_bytes` is 0.
- R7: `len_req` is a one-cycle pulse on the cycle after the last read. If both counts are zero, it comes on the first busy cycle. During the operation, `len_block` = {aad_bytes*8 as 64 bits, pay_bytes*8 as 64 bits}.
- R8: `tag_valid` is high for exactly one cycle, on the first cycle after finish, in which `busy` is low.
- R9: `len_done` has no effect unless the sequencer is waiting after `len_req`.
- R10: A start pulse while busy is ignored.
- R11: While `rst_n` is low, the sequencer is idle and `busy`, `rd_en`, `dout_valid`, `len_req`, `finish` and `tag_valid` are all low.
- R12: A start on the cycle after finish is accepted with its new parameters. The operations then run back to back.
- R13: With zero associated data, the first read is a payload word. With both counts zero, no word is read and the length step starts at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse |
| decrypt | input | 1 | Direction: 1 decrypt, 0 encrypt |
| aad_bytes | input | 16 | Associated-data length in bytes |
| pay_bytes | input | 16 | Payload length in bytes |
| len_done | input | 1 | Hash engine has absorbed the length block |
| busy | output | 1 | Operation in progress |
| finish | output | 1 | Last cycle of the operation |
| rd_en | output | 1 | Input word is read this cycle |
| rd_is_aad | output | 1 | The word being read is associated data |
| dout_valid | output | 1 | Output word valid |
| len_req | output | 1 | Request to hash the length block |
| len_block | output | 128 | Length block: associated-data bits, then payload bits |
| op_decrypt | output | 1 | Captured direction |
| tag_valid | output | 1 | Tag available |

## Verification
The hardest case to reach is a restart that lands exactly on the tag-valid cycle of the previous operation. The stimulus must drive the handshake reply and the new start to the exact cycle. To get there, the bench acts as the hash engine itself. From the counts it computes the cycle of the length request and the cycle of its own reply. On the predicted tag cycle it raises the next start with fresh counts. Spurious `len_done` pulses in the read and request phases are also driven, to show that they are ignored. So is a start pulse mid-operation, together with scrambled parameter inputs.

// File: rtl/aead_seq.sv
module aead_seq #(
  parameter int CNT_W   = 16,
  parameter int CADENCE = 14,
  parameter int BLK_W   = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             decrypt,
  input  logic [CNT_W-1:0] aad_bytes,
  input  logic [CNT_W-1:0] pay_bytes,
  input  logic             len_done,
  output logic             busy,
  output logic             finish,
  output logic             rd_en,
  output logic             rd_is_aad,
  output logic             dout_valid,
  output logic             len_req,
  output logic [BLK_W-1:0] len_block,
  output logic             op_decrypt,
  output logic             tag_valid
);
  localparam int TICK_W = $clog2(CADENCE);
  localparam int WORD_W = CNT_W - 2;
  localparam int LEN_W  = BLK_W / 2;

  typedef enum logic [1:0] {S_IDLE, S_READ, S_LEN, S_WAIT} st_t;

  st_t               state;
  logic [TICK_W-1:0] tick;
  logic [WORD_W-1:0] aad_left, words_left;
  logic [CNT_W-1:0]  aad_q, pay_q;
  logic              dout_q, tag_q;

  logic [CNT_W:0]    aad_rnd, pay_rnd;
  logic [WORD_W-1:0] aad_w_in, pay_w_in, total_in;

  assign aad_rnd  = {1'b0, aad_bytes} + (CNT_W+1)'(15);
  assign pay_rnd  = {1'b0, pay_bytes} + (CNT_W+1)'(15);
  assign aad_w_in = WORD_W'(aad_rnd >> 4);
  assign pay_w_in = WORD_W'(pay_rnd >> 4);
  assign total_in = aad_w_in + pay_w_in;

  assign busy       = state != S_IDLE;
  assign rd_en      = (state == S_READ) && (tick == '0);
  assign rd_is_aad  = rd_en && (aad_left != '0);
  assign len_req    = state == S_LEN;
  assign finish     = (state == S_WAIT) && len_done;
  assign dout_valid = dout_q;
  assign tag_valid  = tag_q;
  assign len_block  = {LEN_W'({aad_q, 3'b000}), LEN_W'({pay_q, 3'b000})};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      tick       <= '0;
      aad_left   <= '0;
      words_left <= '0;
      aad_q      <= '0;
      pay_q      <= '0;
      op_decrypt <= 1'b0;
      dout_q     <= 1'b0;
      tag_q      <= 1'b0;
    end else begin
      dout_q <= rd_en && (aad_left == '0);
      tag_q  <= finish;
      case (state)
        S_IDLE: if (start) begin
          aad_q      <= aad_bytes;
          pay_q      <= pay_bytes;
          op_decrypt <= decrypt;
          aad_left   <= aad_w_in;
          words_left <= total_in;
          tick       <= '0;
          state      <= (total_in == '0) ? S_LEN : S_READ;
        end
        S_READ: if (tick == '0) begin
          words_left <= words_left - 1'b1;
          if (aad_left != '0) aad_left <= aad_left - 1'b1;
          tick <= TICK_W'(CADENCE - 1);
          if (words_left == WORD_W'(1)) state <= S_LEN;
        end else begin
          tick <= tick - 1'b1;
        end
        S_LEN:  state <= S_WAIT;
        S_WAIT: if (len_done) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  logic [TICK_W:0] gap;
  logic            seen_rd;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap     <= '0;
      seen_rd <= 1'b0;
    end else if (start && !busy) begin
      seen_rd <= 1'b0;
      gap     <= '0;
    end else if (rd_en) begin
      seen_rd <= 1'b1;
      gap     <= (TICK_W+1)'(1);
    end else if (gap != '0 && gap != '1) begin
      gap <= gap + 1'b1;
    end
  end

  assert_busy_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  assert_finish_ends_op_R3: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (!busy && tag_valid));
  assert_read_cadence_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && seen_rd) |-> (gap == (TICK_W+1)'(CADENCE)));
  assert_dout_after_payload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> ($past(rd_en) && !$past(rd_is_aad)));
  assert_tag_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tag_valid |=> !tag_valid);
  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(op_decrypt) && $stable(len_block)));
  assert_strobes_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_en, len_req, finish}));
endmodule

// File: tb/tb_aead_seq.sv
module tb_aead_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        decrypt = 1'b0;
  logic [15:0] aad_bytes = '0;
  logic [15:0] pay_bytes = '0;
  logic        len_done = 1'b0;
  logic        busy, finish, rd_en, rd_is_aad, dout_valid, len_req, op_decrypt, tag_valid;
  logic [127:0] len_block;

  int n_checks = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  aead_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .decrypt(decrypt),
    .aad_bytes(aad_bytes), .pay_bytes(pay_bytes), .len_done(len_done),
    .busy(busy), .finish(finish), .rd_en(rd_en), .rd_is_aad(rd_is_aad),
    .dout_valid(dout_valid), .len_req(len_req), .len_block(len_block),
    .op_decrypt(op_decrypt), .tag_valid(tag_valid)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk({busy, rd_en, dout_valid, len_req, finish, tag_valid} == 6'b0, "R11",
        "strobes in reset", {busy, rd_en, dout_valid, len_req, finish, tag_valid}, 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_op(input int a, input int p, input bit dec, input int d,
                        input bit pre, input bit chain,
                        input int a2, input int p2, input bit dec2);
    int na, np, n, lenc, donec;
    int e_rd, e_aad, e_dv, e_len, e_blk, e_fin, e_busy, e_tag, e_mode;
    longint blk_exp;
    na = (a + 15) / 16;
    np = (p + 15) / 16;
    n = na + np;
    lenc = (n > 0) ? 14 * (n - 1) + 1 : 0;
    donec = lenc + 1 + d;
    blk_exp = 0;
    e_rd = 0; e_aad = 0; e_dv = 0; e_len = 0; e_blk = 0;
    e_fin = 0; e_busy = 0; e_tag = 0; e_mode = 0;
    if (!pre) begin
      @(negedge clk);
      start = 1'b1; aad_bytes = 16'(a); pay_bytes = 16'(p); decrypt = dec;
      @(negedge clk);
      start = 1'b0;
    end
    for (int c = 0; c <= donec + 1; c++) begin
      bit x_rd, x_aad, x_dv;
      if (c > 0) @(negedge clk);
      len_done = (c == 0) || (c == lenc) || (c == donec);
      if (c == 1) begin
        start = 1'b1; decrypt = ~dec; aad_bytes = 16'hFFFF; pay_bytes = 16'h1234;
      end
      if (c == 2) start = 1'b0;
      #1;
      x_rd  = (c < 14 * n) && (c % 14 == 0);
      x_aad = x_rd && (c / 14 < na);
      x_dv  = (c >= 1) && ((c - 1) % 14 == 0) && ((c - 1) / 14 >= na) && ((c - 1) / 14 < n);
      if (rd_en != x_rd) e_rd++;
      if (x_rd && rd_is_aad != x_aad) e_aad++;
      if (dout_valid != x_dv) e_dv++;
      if (len_req != (c == lenc)) e_len++;
      if (finish != (c == donec)) e_fin++;
      if (busy != (c <= donec)) e_busy++;
      if (tag_valid != (c == donec + 1)) e_tag++;
      if (c <= donec && op_decrypt != dec) e_mode++;
      if (c == lenc && (len_block[127:64] != 64'(a) * 8 || len_block[63:0] != 64'(p) * 8)) e_blk++;
      if (c == lenc) blk_exp = len_block[127:64];
    end
    len_done = 1'b0;
    chk(e_rd == 0, "R4", "read cadence mismatches", e_rd, 0);
    chk(e_aad == 0, "R5", "aad/payload order mismatches", e_aad, 0);
    chk(e_dv == 0, "R6", "dout_valid mismatches", e_dv, 0);
    chk(e_len == 0, "R7", "len_req mismatches", e_len, 0);
    chk(e_blk == 0, "R7", "len_block aad bits", blk_exp, longint'(a) * 8);
    chk(e_fin == 0, "R3", "finish mismatches (R9 spurious len_done)", e_fin, 0);
    chk(e_busy == 0, "R2", "busy mismatches (R10 start while busy)", e_busy, 0);
    chk(e_tag == 0, "R8", "tag_valid mismatches", e_tag, 0);
    chk(e_mode == 0, "R1", "op_decrypt held", e_mode, 0);
    if (chain) begin
      start = 1'b1; aad_bytes = 16'(a2); pay_bytes = 16'(p2); decrypt = dec2;
      @(negedge clk);
      start = 1'b0;
    end else begin
      start = 1'b0;
    end
  endtask

  task automatic test_basic_unaligned();   run_op(20, 33, 1'b0, 2, 1'b0, 1'b0, 0, 0, 1'b0); endtask
  task automatic test_aligned_decrypt();   run_op(32, 48, 1'b1, 0, 1'b0, 1'b0, 0, 0, 1'b0); endtask
  task automatic test_zero_aad_R13();      run_op(0, 17, 1'b0, 1, 1'b0, 1'b0, 0, 0, 1'b0); endtask
  task automatic test_zero_payload_R6();   run_op(5, 0, 1'b1, 4, 1'b0, 1'b0, 0, 0, 1'b0); endtask
  task automatic test_zero_both_R13();     run_op(0, 0, 1'b0, 3, 1'b0, 1'b0, 0, 0, 1'b0); endtask
  task automatic test_back_to_back_R12();
    run_op(16, 16, 1'b1, 0, 1'b0, 1'b1, 0, 40, 1'b0);
    run_op(0, 40, 1'b0, 2, 1'b1, 1'b1, 3, 0, 1'b1);
    run_op(3, 0, 1'b1, 0, 1'b1, 1'b0, 0, 0, 1'b0);
  endtask

  task automatic test_reset_midop_R11();
    @(negedge clk);
    start = 1'b1; aad_bytes = 16'd64; pay_bytes = 16'd64; decrypt = 1'b0;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk({busy, rd_en, dout_valid, len_req, finish, tag_valid} == 6'b0, "R11",
        "strobes after mid-op reset", {busy, rd_en, dout_valid, len_req, finish, tag_valid}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(busy == 1'b0, "R11", "idle after reset release", busy, 0);
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    check_reset();
    test_basic_unaligned();
    test_aligned_decrypt();
    test_zero_aad_R13();
    test_zero_payload_R6();
    test_zero_both_R13();
    test_back_to_back_R12();
    test_reset_midop_R11();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule